// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block runs one processor machine cycle on a bus whose low address byte and data byte share the same eight wires. A requester names the kind of cycle and hands over an address and, for writes, a data byte. The block then steps through timing states, one per clock. The first state presents the address with the latch-enable strobe. The middle states drive the active-low read or write strobe. Wait and hold states are inserted as the slave or another bus master asks. An opcode fetch ends with an extra decode state.

Three status lines are set when a cycle begins and keep their value until the next cycle begins, so external logic can tell what kind of transfer is in progress. Bytes read from the bus are captured and kept on a result port. The requester sees a busy flag for the length of the cycle and a one-clock done pulse in its final state.

The shared byte lane is modelled as separate in, out and enable signals. The high address byte and the strobes have a common drive enable that is released while another master holds the bus.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: The status triple {ioM,s1,s0} takes the value of the requested kind in the first state of a cycle and keeps it until the next accepted cycle. The kind codes on reqKind are 0 opcode fetch (0,1,1), 1 memory read (0,1,0), 2 memory write (0,0,1), 3 I/O read (1,1,0) and 4 I/O write (1,0,1). After reset the triple is (0,0,0).
- R2: In the first state, ale is 1, addrHi carries the upper address byte, adOut carries the lower address byte, adOe is 1, and both strobes are high. ale is 0 in every other cycle.
- R3: For opcode fetch and the two read kinds, rdN is low in the second state and in every ready-wait state, and high in the third state. The byte on adIn during the third state appears on rdData from the next clock and stays there until another read completes.
- R4: For the two write kinds, adOe is 1 with adOut equal to the write byte, and wrN is low, from the second state through the third state, including ready-wait states. wrN rises at the end of the third state, and adOut keeps the write byte after that.
- R5: While ready is 0 at the end of the second state or of a wait state, the block inserts one more wait state per such clock. The third state follows the first clock that ends with ready at 1 and hold at 0.
- R6: When hold is 1 at the end of the second state or of a wait state, the block enters hold states. In a hold state busOe and adOe are 0 and both strobes are high. Hold has priority over ready. When hold returns to 0, the block repeats the second state and then checks ready again.
- R7: An opcode fetch has a fourth state after the third, with rdN high and adOe 0. Without wait states it takes four clocks.
- R8: Memory and I/O reads and writes end after the third state and take three clocks without wait states.
- R9: busy is 1 from the first state through the final state. done is 1 only in the final state, and busy is 0 on the clock after done. A request is accepted only while busy is 0, and the first state follows on the next clock. Requests made while busy have no effect.
- R10: For the I/O kinds, the port number reqAddr[7:0] appears both on addrHi and on adOut in the first state.
- R11: adOe is 0 whenever the block is neither in the first state nor driving write data. A request with a kind code of 5, 6 or 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request a machine cycle |
| reqKind | input | 3 | Cycle kind code (see R1) |
| reqAddr | input | 16 | Memory address; for I/O only bits 7:0 are used |
| reqWrData | input | 8 | Byte to write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Final state of the cycle |
| rdData | output | 8 | Last byte read |
| ready | input | 1 | Slave ready; 0 inserts wait states |
| hold | input | 1 | Another master asks for the bus |
| addrHi | output | 8 | Upper address byte |
| adOut | output | 8 | Shared lane, driven value |
| adIn | input | 8 | Shared lane, received value |
| adOe | output | 1 | Drive enable for the shared lane |
| busOe | output | 1 | Drive enable for addrHi and the strobes |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | Status: 1 for I/O, 0 for memory |
| s1 | output | 1 | Status line 1 |
| s0 | output | 1 | Status line 0 |

## Verification
The assertions check these rules on every clock: ale lasts a single clock and never coincides with a strobe, the two strobes are never low together, the shared lane is never driven while rdN is low, a hold state floats everything, status changes only with ale, and done ends busy. Only the bench's scenarios can show the cycle-accurate sequence of the states. That sequence covers where the address and write data sit, how many wait or hold states each ready/hold pattern produces, the resumption at the second state after hold, the I/O port copy, the captured read byte, and that requests are ignored while busy or when the kind code is invalid.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    KIND_OPF  = 3'd0,
    KIND_MRD  = 3'd1,
    KIND_MWR  = 3'd2,
    KIND_IORD = 3'd3,
    KIND_IOWR = 3'd4
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_WAIT = 3'd3,
    ST_HOLD = 3'd4,
    ST_T3   = 3'd5,
    ST_T4   = 3'd6
  } tState_e;

  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic accept;
    logic addrPhase;
    logic readStrobe;
    logic writeStrobe;
    logic capture;
    logic floatBus;
  } dpStrobe_t;

  function automatic logic kindValid(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic isWrite(input cycKind_e k);
    return (k == KIND_MWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic isRead(input cycKind_e k);
    return (k == KIND_OPF) || (k == KIND_MRD) || (k == KIND_IORD);
  endfunction

  function automatic logic isIo(input cycKind_e k);
    return (k == KIND_IORD) || (k == KIND_IOWR);
  endfunction

  // {ioM, s1, s0}
  function automatic logic [2:0] statusOf(input cycKind_e k);
    case (k)
      KIND_OPF:  return 3'b011;
      KIND_MRD:  return 3'b010;
      KIND_MWR:  return 3'b001;
      KIND_IORD: return 3'b110;
      KIND_IOWR: return 3'b101;
      default:   return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  cycKind_e   curKind,
  input  logic       ready,
  input  logic       hold,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done
);

  tState_e state, stateNext;
  logic    startOk;

  assign startOk = reqValid && kindValid(reqKind);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (startOk) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2, ST_WAIT: begin
        if (hold)        stateNext = ST_HOLD;
        else if (!ready) stateNext = ST_WAIT;
        else             stateNext = ST_T3;
      end
      ST_HOLD: if (!hold) stateNext = ST_T2;
      ST_T3:   stateNext = (curKind == KIND_OPF) ? ST_T4 : ST_IDLE;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  logic strobePhase;
  assign strobePhase = (state == ST_T2) || (state == ST_WAIT);

  always_comb begin
    strobe             = '0;
    strobe.accept      = (state == ST_IDLE) && startOk;
    strobe.addrPhase   = (state == ST_T1);
    strobe.readStrobe  = strobePhase && isRead(curKind);
    strobe.writeStrobe = (strobePhase || (state == ST_T3)) && isWrite(curKind);
    strobe.capture     = (state == ST_T3) && isRead(curKind);
    strobe.floatBus    = (state == ST_HOLD);
  end

  assign busy = (state != ST_IDLE);
  assign done = ((state == ST_T3) && (curKind != KIND_OPF)) || (state == ST_T4);

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [2:0]                reqKind,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWrData,
  input  logic [DATA_W-1:0]         adIn,
  output cycKind_e                  curKind,
  output logic [ADDR_W-DATA_W-1:0]  addrHi,
  output logic [DATA_W-1:0]         adOut,
  output logic                      adOe,
  output logic                      busOe,
  output logic                      ale,
  output logic                      rdN,
  output logic                      wrN,
  output logic                      ioM,
  output logic                      s1,
  output logic                      s0,
  output logic [DATA_W-1:0]         rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  cycKind_e          kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [2:0]        statusQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= KIND_MRD;
      addrQ   <= '0;
      wdQ     <= '0;
      statusQ <= 3'b000;
      rdQ     <= '0;
    end else begin
      if (strobe.accept) begin
        kindQ   <= cycKind_e'(reqKind);
        addrQ   <= reqAddr;
        wdQ     <= reqWrData;
        statusQ <= statusOf(cycKind_e'(reqKind));
      end
      if (strobe.capture) rdQ <= adIn;
    end
  end

  // port number copied to the upper lane, width-matched
  logic [DATA_W-1:0] portNum;
  logic [HI_W-1:0]   portHi;
  assign portNum = addrQ[DATA_W-1:0];

  generate
    if (HI_W == DATA_W) begin : g_hiEq
      assign portHi = portNum;
    end else if (HI_W > DATA_W) begin : g_hiWide
      assign portHi = {{(HI_W-DATA_W){1'b0}}, portNum};
    end else begin : g_hiNarrow
      assign portHi = portNum[HI_W-1:0];
    end
  endgenerate

  logic ioCyc;
  assign ioCyc  = isIo(kindQ);

  assign curKind = kindQ;
  assign addrHi  = ioCyc ? portHi : addrQ[ADDR_W-1:DATA_W];
  assign adOut   = strobe.addrPhase ? portNum : wdQ;
  assign adOe    = strobe.addrPhase || strobe.writeStrobe;
  assign busOe   = !strobe.floatBus;
  assign ale     = strobe.addrPhase;
  assign rdN     = !strobe.readStrobe;
  assign wrN     = !strobe.writeStrobe;
  assign {ioM, s1, s0} = statusQ;
  assign rdData  = rdQ;

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     ready,
  input  logic                     hold,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     adOe,
  output logic                     busOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     s1,
  output logic                     s0
);

  dpStrobe_t strobe;
  cycKind_e  curKind;

  mbus_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .curKind(curKind), .ready(ready), .hold(hold), .strobe(strobe),
    .busy(busy), .done(done)
  );

  mbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .adIn(adIn),
    .curKind(curKind), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
    .busOe(busOe), .ale(ale), .rdN(rdN), .wrN(wrN),
    .ioM(ioM), .s1(s1), .s0(s0), .rdData(rdData)
  );

endmodule

// File: rtl/mbus_cycle_ctrl_chk.sv
module mbus_cycle_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic adOe,
  input logic busOe,
  input logic busy,
  input logic done,
  input logic ioM,
  input logic s1,
  input logic s0
);

  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && adOe));

  a_r1_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ale |-> $stable({ioM, s1, s0}));

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  a_r6_float_all: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (!adOe && rdN && wrN && busy));

  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r9_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind mbus_cycle_ctrl mbus_cycle_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN), .adOe(adOe),
  .busOe(busOe), .busy(busy), .done(done), .ioM(ioM), .s1(s1), .s0(s0)
);

// File: tb/mbus_cycle_ctrl_tb_top.sv
module mbus_cycle_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWrData = '0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic [7:0]  adIn = '0;
  logic        busy, done, adOe, busOe, ale, rdN, wrN, ioM, s1, s0;
  logic [7:0]  rdData, addrHi, adOut;

  int nChecks = 0;
  int nErrors = 0;
  logic [2:0] lastStatus = 3'b000;
  logic [1:0] pat[$];   // {ready, hold} per wait-checking clock

  always #4 clk = ~clk;

  mbus_cycle_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busy(busy), .done(done),
    .rdData(rdData), .ready(ready), .hold(hold), .addrHi(addrHi),
    .adOut(adOut), .adIn(adIn), .adOe(adOe), .busOe(busOe), .ale(ale),
    .rdN(rdN), .wrN(wrN), .ioM(ioM), .s1(s1), .s0(s0)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expStatus(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  // behavioural model: phase 1..4 = timing states, 5 = ready wait, 6 = hold
  task automatic runCycle(input logic [2:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] rb,
                          input bit noisy, input int expClocks);
    bit wr, rd, fetch, io, lastPh;
    logic [7:0] hiE, loE;
    logic [2:0] st;
    logic r, h;
    int ph, clocks;
    wr = (k == 3'd2) || (k == 3'd4);
    rd = !wr;
    fetch = (k == 3'd0);
    io = (k == 3'd3) || (k == 3'd4);
    hiE = io ? a[7:0] : a[15:8];
    loE = a[7:0];
    st = expStatus(k);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWrData = wd;
    @(posedge clk);
    ph = 1; clocks = 0;
    while (ph != 0) begin
      @(negedge clk);
      clocks++;
      if (noisy) begin
        reqValid = 1'b1; reqKind = 3'd2; reqAddr = 16'hFFFF; reqWrData = 8'hEE;
      end else reqValid = 1'b0;
      chk("R1", "status", {ioM, s1, s0}, st);
      chk("R9", "busy", busy, 1'b1);
      chk("R2", "ale", ale, ph == 1);
      lastPh = (ph == 3 && !fetch) || ph == 4;
      chk("R9", "done", done, lastPh);
      case (ph)
        1: begin
          chk("R2", "addrHi", addrHi, hiE);
          chk(io ? "R10" : "R2", "adOut addr", adOut, loE);
          chk("R2", "adOe T1", adOe, 1'b1);
          chk("R2", "strobes T1", {rdN, wrN}, 2'b11);
        end
        2, 5: begin
          chk("R5", "busOe", busOe, 1'b1);
          chk("R3", "rdN mid", rdN, !rd);
          chk("R4", "wrN mid", wrN, !wr);
          chk("R11", "adOe mid", adOe, wr);
          if (wr) chk("R4", "wdata mid", adOut, wd);
        end
        6: begin
          chk("R6", "busOe hold", busOe, 1'b0);
          chk("R6", "adOe hold", adOe, 1'b0);
          chk("R6", "strobes hold", {rdN, wrN}, 2'b11);
        end
        3: begin
          chk("R3", "rdN T3", rdN, 1'b1);
          chk("R4", "wrN T3", wrN, !wr);
          chk("R4", "adOe T3", adOe, wr);
          if (wr) chk("R4", "wdata T3", adOut, wd);
        end
        default: begin
          chk("R7", "strobes T4", {rdN, wrN}, 2'b11);
          chk("R7", "adOe T4", adOe, 1'b0);
        end
      endcase
      if (lastPh) reqValid = 1'b0;
      r = 1'b1; h = 1'b0;
      if ((ph == 2 || ph == 5 || ph == 6) && pat.size() > 0) {r, h} = pat.pop_front();
      ready = r; hold = h;
      adIn = (ph == 3) ? rb : 8'hA5;
      @(posedge clk);
      case (ph)
        1: ph = 2;
        2, 5: ph = h ? 6 : (!r ? 5 : 3);
        6: ph = h ? 6 : 2;
        3: ph = fetch ? 4 : 0;
        default: ph = 0;
      endcase
    end
    ready = 1'b1; hold = 1'b0;
    @(negedge clk);
    chk(fetch ? "R7" : "R8", "clock count", clocks, expClocks);
    chk("R9", "busy after", busy, 1'b0);
    chk("R9", "done after", done, 1'b0);
    chk("R11", "adOe idle", adOe, 1'b0);
    chk("R2", "ale idle", ale, 1'b0);
    chk("R1", "status held", {ioM, s1, s0}, st);
    if (rd) chk("R3", "rdData", rdData, rb);
    else    chk("R4", "wdata kept", adOut, wd);
    lastStatus = st;
  endtask

  initial begin
    #(8 * 20000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", busy, 1'b0);
    chk("R1", "reset status", {ioM, s1, s0}, 3'b000);
    chk("R11", "reset adOe", adOe, 1'b0);
    chk("R3", "reset rdData", rdData, 8'h00);

    // fetch, no waits
    runCycle(3'd0, 16'h2105, 8'h00, 8'h41, 1'b0, 4);
    // memory read, two ready waits
    pat = '{2'b00, 2'b00};
    runCycle(3'd1, 16'h1001, 8'h00, 8'h06, 1'b0, 5);
    // memory write with requests held high while busy, one wait
    pat = '{2'b00};
    runCycle(3'd2, 16'h3000, 8'h5A, 8'h00, 1'b1, 4);
    // I/O read, upper address bits must not leak
    runCycle(3'd3, 16'hAB7C, 8'h00, 8'hC3, 1'b0, 3);
    // I/O write with two hold clocks, then resume at T2
    pat = '{2'b11, 2'b11, 2'b10};
    runCycle(3'd4, 16'h5511, 8'h99, 8'h00, 1'b0, 6);
    // memory read: wait, hold beats ready low, back to T2, wait
    pat = '{2'b00, 2'b01, 2'b10, 2'b00};
    runCycle(3'd1, 16'h4242, 8'h00, 8'h3E, 1'b0, 7);
    // fetch with one wait
    pat = '{2'b00};
    runCycle(3'd0, 16'hFFFE, 8'h00, 8'h76, 1'b0, 5);

    // invalid kind codes are ignored
    for (int bad = 5; bad < 8; bad++) begin
      reqValid = 1'b1; reqKind = 3'(bad); reqAddr = 16'h1234;
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      chk("R11", "bad kind busy", busy, 1'b0);
      chk("R11", "bad kind ale", ale, 1'b0);
      chk("R11", "bad kind status", {ioM, s1, s0}, lastStatus);
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule